// File: doc/BRIEF.md
# Maximum-Length Sequence Impulse Response Correlator

The block measures the impulse response of an external system by exciting it with a pseudorandom binary sequence of period L = 2^ORDER − 1 and cross-correlating what comes back against that excitation. Each stimulus bit stands for a symbol of value +1 or −1. The autocorrelation of such a sequence is close to a single spike, so the circular cross-correlation at lag k, divided by L, gives an estimate of the impulse response tap h(k).

A pulse on `start` first runs the internal generator through one full period. This fills a short history of recent stimulus bits, so that lags reaching back before sample 0 wrap to the end of the period. The block then raises `smp_ready` and presents the current stimulus symbol on `stim_bit`. Each accepted sample y(j) is paired with the symbol shown when it is accepted. Once L samples have been taken, the LAGS scaled results are offered on a valid/ready result stream in lag order.

Both streams follow the usual valid/ready rule: a transfer happens on a rising clock edge where valid and ready are both high. The result stream holds its data and its last flag for as long as the consumer stalls it. The sample stream applies back-pressure by keeping ready low outside the capture phase.

Top module: `mls_correlator`

## Requirements
- R1: After reset, `busy`, `smp_ready` and `res_valid` are low. Whenever `busy` is low, `smp_ready` and `res_valid` are low too.
- R2: A `start` pulse while idle raises `busy`. `smp_ready` stays low for exactly L cycles of priming before the capture phase begins.
- R3: Over one capture the L stimulus bits hold 2^(ORDER−1) ones. All L circular windows of ORDER consecutive bits are distinct and nonzero. Every measurement repeats the same sequence, and the generator state is never zero.
- R4: `stim_bit` = 1 stands for +1 and 0 for −1. Sample j is paired with the `stim_bit` value present in its accept cycle. During capture, `stim_bit` changes only after an accepted sample.
- R5: The result at lag k equals the nearest integer to (1/L)·Σ_j x((j−k) mod L)·y(j), where j runs over the L accepted samples. Lags before sample 0 wrap to the end of the period.
- R6: Full-scale samples, including the most negative code, accumulate without overflow. A correlation whose scaled value is −128 or +127 is reported exactly.
- R7: Exactly LAGS results are emitted, in order of lag 0 to LAGS−1. `res_last` is high only with lag LAGS−1.
- R8: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_data` and `res_last` hold their values into the next cycle.
- R9: `smp_ready` is low outside the capture phase. Samples offered then are not taken: exactly L samples enter each measurement, and data offered during result output does not change any later result.
- R10: `start` is ignored while `busy` is high. Neither the capture in progress nor its results are disturbed.
- R11: The cycle after the handshake of the last result, `busy` is low and a new measurement can be started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a measurement when idle |
| busy | output | 1 | Measurement in progress |
| stim_bit | output | 1 | Current stimulus symbol (1 = +1, 0 = −1) |
| smp_valid | input | 1 | Response sample valid |
| smp_ready | output | 1 | Sample accepted this cycle if valid |
| smp_data | input | SAMPLE_W | Signed response sample y(j) |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer accepts result |
| res_data | output | SAMPLE_W+1 | Signed scaled correlation for the current lag |
| res_last | output | 1 | Marks the result for lag LAGS−1 |

## Verification
The hardest case to reach from the ports is the circular wrap. The lags of the first few samples must use stimulus bits from the end of the period, and those bits were produced during priming, where they cannot be seen. The bench records the sequence in a first measurement and relies on R3's repeatability. It then drives a modelled FIR response computed circularly from that recorded sequence, so every early sample carries wrapped terms. Other runs combine capture gaps, a `start` pulse during capture, junk samples offered while results stream out, and a stalling result consumer.

// File: rtl/mls_corr_pkg.sv
package mls_corr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRIME,
    ST_CAPTURE,
    ST_EMIT
  } corr_state_e;

  // Feedback taps for a right-shifting generator whose new bit enters the
  // top: bit i set means state bit i joins the XOR. Each set is a primitive
  // trinomial or pentanomial for the order.
  function automatic logic [31:0] fb_taps(input int order);
    case (order)
      3:       return 32'h0000_0003;
      4:       return 32'h0000_0003;
      5:       return 32'h0000_0005;
      6:       return 32'h0000_0003;
      7:       return 32'h0000_0003;
      8:       return 32'h0000_0071;
      default: return 32'h0000_0003;
    endcase
  endfunction

endpackage

// File: rtl/mls_lfsr.sv
module mls_lfsr #(
  parameter int ORDER = 4,
  parameter int SEED  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic step,
  output logic bit_out
);
  import mls_corr_pkg::*;

  localparam logic [31:0]      TAP_FULL = fb_taps(ORDER);
  localparam logic [ORDER-1:0] TAPS     = TAP_FULL[ORDER-1:0];
  localparam logic [ORDER-1:0] SEED_V   = ORDER'(SEED);

  logic [ORDER-1:0] st_q;
  logic             fb;

  assign fb      = ^(st_q & TAPS);
  assign bit_out = st_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SEED_V;
    end else if (load) begin
      st_q <= SEED_V;
    end else if (step) begin
      st_q <= {fb, st_q[ORDER-1:1]};
    end
  end

  // R3: the generator never falls into the locked all-zero state
  p_state_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != '0);

endmodule

// File: rtl/mls_lag_bank.sv
module mls_lag_bank #(
  parameter int LAGS     = 4,
  parameter int SAMPLE_W = 8,
  parameter int ACC_W    = 12,
  parameter int IDX_W    = 2,
  parameter int PERIOD   = 15
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       shift,
  input  logic                       accum,
  input  logic                       cur_bit,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic        [IDX_W-1:0]    rd_idx,
  output logic signed [ACC_W-1:0]    rd_acc
);

  localparam longint BOUND = longint'(PERIOD) * (longint'(1) << (SAMPLE_W - 1));

  logic [LAGS-2:0]          hist_q;
  logic [LAGS-1:0]          lag_bit;
  logic signed [ACC_W-1:0]  ext;
  logic signed [ACC_W-1:0]  acc_q [LAGS];

  assign ext = {{(ACC_W - SAMPLE_W){sample[SAMPLE_W-1]}}, sample};

  // Recent stimulus history: hist_q[i] holds the bit from i+1 steps ago.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else if (shift) begin
      hist_q[0] <= cur_bit;
      for (int i = 1; i < LAGS - 1; i++) begin
        hist_q[i] <= hist_q[i-1];
      end
    end
  end

  assign lag_bit[0] = cur_bit;

  for (genvar k = 0; k < LAGS; k++) begin : g_lag
    if (k > 0) begin : g_hist_tap
      assign lag_bit[k] = hist_q[k-1];
    end

    // A +1 symbol adds the sample, a -1 symbol subtracts it.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q[k] <= '0;
      end else if (clear) begin
        acc_q[k] <= '0;
      end else if (accum) begin
        acc_q[k] <= lag_bit[k] ? (acc_q[k] + ext) : (acc_q[k] - ext);
      end
    end

    // R6: an accumulator never leaves the range that L full-scale samples span
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      accum |=> (longint'(acc_q[k]) <= BOUND && longint'(acc_q[k]) >= -BOUND));
  end

  assign rd_acc = acc_q[rd_idx];

endmodule

// File: rtl/mls_scaler.sv
module mls_scaler #(
  parameter int ACC_W  = 12,
  parameter int RES_W  = 9,
  parameter int PERIOD = 15,
  parameter int FRAC   = 17
) (
  input  logic signed [ACC_W-1:0] acc_in,
  output logic signed [RES_W-1:0] res_out
);

  localparam int          PW     = ACC_W + FRAC + 1;
  localparam logic [63:0] RECIP64 =
    ((64'd1 << FRAC) + 64'(PERIOD / 2)) / 64'(PERIOD);
  localparam logic [FRAC:0] RECIP = RECIP64[FRAC:0];
  localparam logic [PW-1:0] HALF  = PW'(64'd1 << (FRAC - 1));

  logic             neg;
  logic [ACC_W-1:0] mag;
  logic [PW-1:0]    prod;
  logic [PW-1:0]    rounded;
  logic [ACC_W:0]   quo;
  logic [ACC_W:0]   signed_quo;

  // Work on the magnitude so rounding goes to the nearest integer for both
  // signs; an odd period never gives an exact half.
  assign neg        = acc_in[ACC_W-1];
  assign mag        = neg ? (~acc_in + 1'b1) : acc_in;
  assign prod       = PW'(mag) * PW'(RECIP);
  assign rounded    = prod + HALF;
  assign quo        = (ACC_W + 1)'(rounded >> FRAC);
  assign signed_quo = neg ? (~quo + 1'b1) : quo;
  assign res_out    = RES_W'(signed_quo);

endmodule

// File: rtl/mls_correlator.sv
module mls_correlator #(
  parameter int ORDER    = 4,
  parameter int LAGS     = 4,
  parameter int SAMPLE_W = 8,
  parameter int SEED     = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  output logic                         busy,
  output logic                         stim_bit,
  input  logic                         smp_valid,
  output logic                         smp_ready,
  input  logic signed [SAMPLE_W-1:0]   smp_data,
  output logic                         res_valid,
  input  logic                         res_ready,
  output logic signed [SAMPLE_W:0]     res_data,
  output logic                         res_last
);
  import mls_corr_pkg::*;

  localparam int PERIOD = (1 << ORDER) - 1;
  localparam int ACC_W  = SAMPLE_W + ORDER;
  localparam int RES_W  = SAMPLE_W + 1;
  localparam int IDX_W  = (LAGS > 1) ? $clog2(LAGS) : 1;
  localparam int CNT_W  = ORDER;
  localparam int FRAC   = 2 * ORDER + SAMPLE_W + 1;
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(PERIOD - 1);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(LAGS - 1);

  corr_state_e             state_q;
  logic [CNT_W-1:0]        cnt_q;
  logic [IDX_W-1:0]        idx_q;
  logic                    smp_fire;
  logic                    res_fire;
  logic                    gen_load;
  logic                    gen_step;
  logic                    cur_bit;
  logic signed [ACC_W-1:0] sel_acc;
  logic signed [RES_W-1:0] scaled;

  assign busy      = (state_q != ST_IDLE);
  assign smp_ready = (state_q == ST_CAPTURE);
  assign res_valid = (state_q == ST_EMIT);
  assign res_last  = res_valid && (idx_q == IDX_END);
  assign res_data  = scaled;
  assign stim_bit  = cur_bit;

  assign smp_fire = smp_valid && smp_ready;
  assign res_fire = res_valid && res_ready;
  assign gen_load = (state_q == ST_IDLE) && start;
  assign gen_step = (state_q == ST_PRIME) || smp_fire;

  mls_lfsr #(
    .ORDER (ORDER),
    .SEED  (SEED)
  ) u_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (gen_load),
    .step    (gen_step),
    .bit_out (cur_bit)
  );

  mls_lag_bank #(
    .LAGS     (LAGS),
    .SAMPLE_W (SAMPLE_W),
    .ACC_W    (ACC_W),
    .IDX_W    (IDX_W),
    .PERIOD   (PERIOD)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (gen_load),
    .shift   (gen_step),
    .accum   (smp_fire),
    .cur_bit (cur_bit),
    .sample  (smp_data),
    .rd_idx  (idx_q),
    .rd_acc  (sel_acc)
  );

  mls_scaler #(
    .ACC_W  (ACC_W),
    .RES_W  (RES_W),
    .PERIOD (PERIOD),
    .FRAC   (FRAC)
  ) u_scale (
    .acc_in  (sel_acc),
    .res_out (scaled)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_PRIME;
            cnt_q   <= '0;
          end
        end
        ST_PRIME: begin
          if (cnt_q == CNT_END) begin
            state_q <= ST_CAPTURE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_CAPTURE: begin
          if (smp_fire) begin
            if (cnt_q == CNT_END) begin
              state_q <= ST_EMIT;
              idx_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_EMIT: begin
          if (res_fire) begin
            if (idx_q == IDX_END) begin
              state_q <= ST_IDLE;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1: both stream handshakes are quiet whenever no measurement runs
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!smp_ready && !res_valid));

  // R2: priming does not end before its last count
  p_prime_span_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PRIME && cnt_q != CNT_END) |=> !smp_ready);

  // R4: the stimulus advances only on an accepted sample during capture
  p_stim_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_ready && !smp_valid) |=> $stable(stim_bit));

  // R7: the last result is always followed by the return to idle
  p_last_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_fire && res_last) |=> !busy);

  // R8: a stalled result holds steady
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_data) && $stable(res_last)));

  // R9: the sample stream is never open while results go out
  p_ready_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_ready && res_valid));

  // R10: start during capture does not leave the capture phase
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_ready && start && !smp_valid) |=> smp_ready);

endmodule

// File: tb/mls_correlator_bench.sv
module mls_correlator_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ORDER      = 4;
  localparam int LAGS       = 4;
  localparam int SAMPLE_W   = 8;
  localparam int L          = (1 << ORDER) - 1;
  localparam int WD_CYCLES  = 20000;

  logic                       clk = 1'b0;
  logic                       rst_n = 1'b0;
  logic                       start = 1'b0;
  logic                       busy;
  logic                       stim_bit;
  logic                       smp_valid = 1'b0;
  logic                       smp_ready;
  logic signed [SAMPLE_W-1:0] smp_data = '0;
  logic                       res_valid;
  logic                       res_ready = 1'b0;
  logic signed [SAMPLE_W:0]   res_data;
  logic                       res_last;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  bit seq [L];
  bit obs [L];
  int ys  [L];
  int expv [LAGS];
  int hfir [LAGS] = '{40, -20, 10, 5};

  always #(CLK_PERIOD / 2) clk = ~clk;

  mls_correlator #(
    .ORDER    (ORDER),
    .LAGS     (LAGS),
    .SAMPLE_W (SAMPLE_W),
    .SEED     (1)
  ) u_mls_correlator (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .stim_bit  (stim_bit),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .smp_data  (smp_data),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_data  (res_data),
    .res_last  (res_last)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int want);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, want);
    end
  endtask

  function automatic int sym(input bit b);
    return b ? 1 : -1;
  endfunction

  function automatic int nearest(input int a);
    if (a >= 0) return (2 * a + L) / (2 * L);
    return -((-2 * a + L) / (2 * L));
  endfunction

  function automatic int ypat(input int p, input int j, input bit b);
    int s;
    case (p)
      0: return j * 7 - 50;
      1: begin
        s = hfir[0] * sym(b);
        for (int i = 1; i < LAGS; i++) s += hfir[i] * sym(seq[(j - i + L) % L]);
        return s;
      end
      2: return b ? -128 : 127;
      3: return b ? 127 : -128;
      4: return ((j * 37) % 256) - 128;
      default: return 0;
    endcase
  endfunction

  task automatic do_run(input int p, input bit gaps, input bit bp,
                        input bit junk, input bit poke, input string req);
    int n;
    int j;
    int cyc;
    int cnt;
    int guard;
    int open_cnt;
    int a;
    bit pend;
    logic signed [SAMPLE_W:0] pd;
    bit r;
    bit same;

    @(negedge clk);
    start = 1'b1;
    n = 0;
    forever begin
      @(negedge clk);
      start = 1'b0;
      if (smp_ready || n > 1000) break;
      n++;
    end
    chk(n == L, "R2", "priming length", n, L);

    j = 0;
    cyc = 0;
    while (j < L && cyc < 2000) begin
      start = 1'b0;
      if (smp_ready && !(gaps && (cyc % 3 == 1))) begin
        obs[j]    = stim_bit;
        ys[j]     = ypat(p, j, stim_bit);
        smp_data  = SAMPLE_W'(ys[j]);
        smp_valid = 1'b1;
        j++;
      end else begin
        smp_valid = 1'b0;
        smp_data  = 8'sd77;
      end
      if (poke && j == 6) start = 1'b1;
      cyc++;
      @(negedge clk);
    end
    start     = 1'b0;
    smp_valid = junk;
    smp_data  = junk ? 8'sd99 : 8'sd0;

    if (p != 0) begin
      same = 1'b1;
      for (int i = 0; i < L; i++) if (obs[i] != seq[i]) same = 1'b0;
      chk(same, "R3", "sequence repeats each measurement", same, 1);
    end

    for (int k = 0; k < LAGS; k++) begin
      a = 0;
      for (int jj = 0; jj < L; jj++) a += sym(obs[(jj - k + L) % L]) * ys[jj];
      expv[k] = nearest(a);
    end

    cnt = 0;
    guard = 0;
    open_cnt = 0;
    pend = 1'b0;
    pd = '0;
    while (cnt < LAGS && guard < 200) begin
      r = bp ? (guard % 3 != 0) : 1'b1;
      if (smp_ready) open_cnt++;
      if (pend) begin
        chk(res_valid && res_data == pd, "R8", "stalled result held",
            int'(res_data), int'(pd));
        pend = 1'b0;
      end
      if (res_valid) begin
        if (r) begin
          chk(int'(res_data) == expv[cnt], req, $sformatf("lag %0d value", cnt),
              int'(res_data), expv[cnt]);
          chk(res_last == (cnt == LAGS - 1), "R7", $sformatf("last flag lag %0d", cnt),
              int'(res_last), int'(cnt == LAGS - 1));
          cnt++;
        end else begin
          pend = 1'b1;
          pd = res_data;
        end
      end
      res_ready = r;
      guard++;
      @(negedge clk);
    end
    res_ready = 1'b0;
    smp_valid = 1'b0;
    chk(cnt == LAGS, "R7", "result count", cnt, LAGS);
    chk(open_cnt == 0, "R9", "sample ready during output", open_cnt, 0);
    chk(!busy && !res_valid, "R11", "idle after last result", int'(busy), 0);
  endtask

  initial begin
    int ones;
    int w;
    bit seen [16];
    bit distinct;

    repeat (3) @(negedge clk);
    chk(!busy && !smp_ready && !res_valid, "R1", "reset outputs quiet",
        int'({busy, smp_ready, res_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !smp_ready && !res_valid, "R1", "idle after reset release",
        int'({busy, smp_ready, res_valid}), 0);

    // R5: ramp response, no stalls; also records the sequence
    do_run(0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");

    ones = 0;
    for (int i = 0; i < L; i++) ones += obs[i];
    chk(ones == (1 << (ORDER - 1)), "R3", "ones per period", ones, 1 << (ORDER - 1));
    for (int i = 0; i < 16; i++) seen[i] = 1'b0;
    distinct = 1'b1;
    for (int i = 0; i < L; i++) begin
      w = 0;
      for (int b = 0; b < ORDER; b++) w |= int'(obs[(i + b) % L]) << b;
      if (w == 0 || seen[w]) distinct = 1'b0;
      seen[w] = 1'b1;
    end
    chk(distinct, "R3", "windows distinct and nonzero", distinct, 1);
    for (int i = 0; i < L; i++) seq[i] = obs[i];

    // R5: circular FIR response, wrapped lags matter at the period start
    do_run(1, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
    // R6: full-scale extremes, lag 0 lands on -128 and +127
    do_run(2, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
    chk(expv[0] == -128, "R6", "negative extreme expectation", expv[0], -128);
    do_run(3, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
    chk(expv[0] == 127, "R6", "positive extreme expectation", expv[0], 127);
    // R4 gaps, R8 stalls, R9 junk during output, R10 start during capture
    do_run(4, 1'b1, 1'b1, 1'b1, 1'b1, "R10");
    // R9: zero response after junk was offered must give zeros
    do_run(5, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
    for (int k = 0; k < LAGS; k++)
      chk(expv[k] == 0, "R9", "zero response expectation", expv[k], 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", WD_CYCLES, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule